// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Clock Divider

This block divides a fast clock by a programmable ratio N. It is built as a digital model of the classic frequency-synthesiser feedback path. A dual-modulus prescaler counts either P or P+1 input cycles per prescaler cycle. A swallow counter keeps the prescaler at the larger modulus for the first A prescaler cycles of every output period. A main counter ends the period after B prescaler cycles. P is 16 or 32, so the ratio is N = P*B + A. This yields every integer ratio in a wide range, while the fast counter only ever counts to P.

A new ratio is presented as one programming word with a load strobe. The prescaler choice is sampled with the same strobe. Each word is checked when it is loaded. A word is held pending and takes effect only at the next period boundary, so an output period never mixes two ratios. A word whose swallow value exceeds its main value is refused. A main value below the minimum is raised to the minimum. Both cases set a sticky error flag.

Top module: `pulse_swallow_divider`

## Requirements
- R1: The interval between consecutive output pulses is N = P*B + A input cycles. P is 16 when the sampled select bit is 0 and 32 when it is 1.
- R2: In the programming word, bits [6:0] carry A and bits [17:7] carry B. The select bit is sampled on the same clock edge as the word, when the load strobe is high.
- R3: The output pulse is exactly one input cycle wide. It is asserted once at the end of each period.
- R4: After reset the ratio is A=0, B=3, P=16 (N=48), and the error flag is low. The first pulse appears 48 cycles after reset is released.
- R5: A word loaded during a period does not change the length of that period. It applies from the following period onward.
- R6: A word with A > B (B after clamping) is refused. The error flag is set and the ratio in force is kept.
- R7: A word with B < 3 is accepted with B replaced by 3, and the error flag is set.
- R8: The error flag stays high until reset, and reset clears it.
- R9: When several valid words are loaded within one period, only the last one takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe: sample prog_word_i and psel_i |
| psel_i | input | 1 | Prescaler choice: 0 gives 16/17, 1 gives 32/33 |
| prog_word_i | input | 18 | Programming word, A in [6:0], B in [17:7] |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each period |
| cfg_err_o | output | 1 | Sticky flag for a refused or clamped word |

## Verification
The case hardest to reach from the ports is a load that arrives partway through a period. The period already running must still finish with the old ratio, and the next period must use the new one. The stimulus times each load a few cycles after an observed pulse. It then measures both the interrupted period and the following one. A second case loads two words back to back inside one period, to show that the later word replaces the earlier one before the boundary.

// File: rtl/psd_pkg.sv
package psd_pkg;
    parameter int A_W   = 7;
    parameter int B_W   = 11;
    parameter int B_MIN = 3;
    parameter int P_LO  = 16;
    parameter int P_HI  = 32;

    localparam int PRE_W  = $clog2(P_HI + 1);
    localparam int WORD_W = A_W + B_W;

    typedef struct packed {
        logic           psel;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } ratio_t;

    localparam ratio_t RATIO_RST = '{psel: 1'b0, a: '0, b: B_W'(B_MIN)};
endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage
    import psd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              psel_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              take_i,
    output ratio_t            pend_o,
    output logic              pend_vld_o,
    output logic              err_o
);
    typedef struct packed {
        ratio_t pend;
        logic   vld;
        logic   err;
    } st_t;

    st_t st_d, st_q;

    logic [A_W-1:0] a_raw;
    logic [B_W-1:0] b_raw, b_fix;
    logic           b_low, refuse;

    always_comb begin
        a_raw  = word_i[A_W-1:0];
        b_raw  = word_i[WORD_W-1:A_W];
        b_low  = b_raw < B_W'(B_MIN);
        b_fix  = b_low ? B_W'(B_MIN) : b_raw;
        refuse = B_W'(a_raw) > b_fix;

        st_d = st_q;
        if (take_i) begin
            st_d.vld = 1'b0;
        end
        if (load_i) begin
            if (b_low || refuse) begin
                st_d.err = 1'b1;
            end
            if (!refuse) begin
                st_d.pend.psel = psel_i;
                st_d.pend.a    = a_raw;
                st_d.pend.b    = b_fix;
                st_d.vld       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pend: RATIO_RST, vld: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o     = st_q.pend;
    assign pend_vld_o = st_q.vld;
    assign err_o      = st_q.err;

    // R8: once raised, the flag never drops without reset
    a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.err |=> st_q.err);

    // R6, R7: any held word is consistent
    a_r6_pend_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |-> (B_W'(st_q.pend.a) <= st_q.pend.b) && (st_q.pend.b >= B_W'(B_MIN)));

    // R6: a refused word leaves the held word untouched
    a_r6_refuse_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && refuse) |=> $stable(st_q.pend));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hi_sel_i,
    input  logic swallow_i,
    output logic tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PRE_W-1:0] top;
    logic             tick;

    always_comb begin
        top = hi_sel_i ? PRE_W'(P_HI) : PRE_W'(P_LO);
        if (!swallow_i) begin
            top = top - PRE_W'(1);
        end
        tick = (st_q.cnt == top);

        st_d = st_q;
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    // R1: modulus only changes while the count is at zero, so it never overshoots
    a_r1_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= top);
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
    import psd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   tick_i,
    input  ratio_t next_i,
    input  logic   next_vld_i,
    output logic   take_o,
    output ratio_t act_o,
    output logic   swallow_o,
    output logic   end_o
);
    typedef struct packed {
        ratio_t         act;
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
    } st_t;

    st_t    st_d, st_q;
    ratio_t nr;
    logic   period_end;

    always_comb begin
        period_end = tick_i && (st_q.b_cnt == B_W'(1));
        nr         = next_vld_i ? next_i : st_q.act;

        st_d = st_q;
        if (tick_i) begin
            if (period_end) begin
                st_d.act   = nr;
                st_d.a_cnt = nr.a;
                st_d.b_cnt = nr.b;
            end else begin
                st_d.b_cnt = st_q.b_cnt - B_W'(1);
                if (st_q.a_cnt != '0) begin
                    st_d.a_cnt = st_q.a_cnt - A_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{act: RATIO_RST, a_cnt: RATIO_RST.a, b_cnt: RATIO_RST.b};
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o    = period_end && next_vld_i;
    assign act_o     = st_q.act;
    assign swallow_o = (st_q.a_cnt != '0);
    assign end_o     = period_end;

    // R5: the ratio in force changes only at a period boundary
    a_r5_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !period_end |=> $stable(st_q.act));

    // R1: swallow phase always ends no later than the period
    a_r1_swallow_le_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
        B_W'(st_q.a_cnt) <= st_q.b_cnt);

    // R1: the main count never runs past its terminal value
    a_r1_main_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.b_cnt != '0);
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import psd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              psel_i,
    input  logic [WORD_W-1:0] prog_word_i,
    output logic              div_pulse_o,
    output logic              cfg_err_o
);
    typedef struct packed {
        logic pulse;
    } st_t;

    st_t    st_d, st_q;
    ratio_t pend, act;
    logic   pend_vld, take, swallow, tick, period_end;

    psd_cfg_stage u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .psel_i     (psel_i),
        .word_i     (prog_word_i),
        .take_i     (take),
        .pend_o     (pend),
        .pend_vld_o (pend_vld),
        .err_o      (cfg_err_o)
    );

    psd_prescaler u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hi_sel_i  (act.psel),
        .swallow_i (swallow),
        .tick_o    (tick)
    );

    psd_swallow_ctrl u_ctl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .next_i     (pend),
        .next_vld_i (pend_vld),
        .take_o     (take),
        .act_o      (act),
        .swallow_o  (swallow),
        .end_o      (period_end)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = period_end;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_pulse_o = st_q.pulse;

    // R3: the divided pulse is a single cycle wide
    a_r3_pulse_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_pulse_o |=> !div_pulse_o);

    // R9: a held word is consumed only at a boundary
    a_r9_take_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> period_end);
endmodule

// File: tb/pulse_swallow_divider_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        psel = 1'b0;
    logic [17:0] word = '0;
    logic        div_pulse_o, cfg_err_o;

    int cyc;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    pulse_swallow_divider dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .load_i      (load),
        .psel_i      (psel),
        .prog_word_i (word),
        .div_pulse_o (div_pulse_o),
        .cfg_err_o   (cfg_err_o)
    );

    // {psel, A[6:0], B[10:0]}
    localparam int NV = 11;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 7'd0,   11'd3},
        {1'b0, 7'd5,   11'd10},
        {1'b1, 7'd0,   11'd4},
        {1'b1, 7'd7,   11'd7},
        {1'b0, 7'd15,  11'd20},
        {1'b1, 7'd31,  11'd31},
        {1'b0, 7'd127, 11'd127},
        {1'b0, 7'd9,   11'd5},
        {1'b1, 7'd0,   11'd1},
        {1'b0, 7'd2,   11'd0},
        {1'b1, 7'd4,   11'd2}
    };

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (!div_pulse_o);
        t = cyc;
    endtask

    task automatic do_load(bit ps, int a, int b);
        @(negedge clk);
        psel = ps;
        word = {11'(b), 7'(a)};   // R2 packing
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        int t0, t1, t2, t;
        int cur_n, new_n, bf;
        bit rej, exp_err;

        // R4: reset state
        repeat (3) @(negedge clk);
        chk("R4 pulse in reset", div_pulse_o, 0);
        chk("R4 err in reset", cfg_err_o, 0);
        rst_n = 1'b1;
        wait_pulse(t);
        chk("R4 first pulse time", t, 48);
        @(negedge clk);
        chk("R3 pulse width", div_pulse_o, 0);

        cur_n   = 48;
        exp_err = 1'b0;
        for (int i = 0; i < NV; i++) begin
            bit ps;
            int a, b;
            string tag;
            ps  = VEC[i][18];
            a   = int'(VEC[i][17:11]);
            b   = int'(VEC[i][10:0]);
            bf  = (b < 3) ? 3 : b;
            rej = (a > bf);
            exp_err = exp_err | (b < 3) | rej;
            new_n = rej ? cur_n : ((ps ? 32 : 16) * bf + a);
            tag = rej ? "R6 refused" : ((b < 3) ? "R7 clamped" : "R1/R2 ratio");

            wait_pulse(t0);
            repeat (5) @(negedge clk);
            do_load(ps, a, b);
            wait_pulse(t1);
            chk("R5 period in flight", t1 - t0, cur_n);
            wait_pulse(t2);
            chk(tag, t2 - t1, new_n);
            chk("R8 err flag", cfg_err_o, exp_err);
            cur_n = new_n;
        end

        // R9: two words in one period, the later wins
        wait_pulse(t0);
        do_load(1'b0, 1, 3);
        do_load(1'b0, 2, 4);
        wait_pulse(t1);
        chk("R5 period in flight", t1 - t0, cur_n);
        wait_pulse(t2);
        chk("R9 last word wins", t2 - t1, 66);

        // R8: reset clears the sticky flag; R4 defaults return
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 err cleared by reset", cfg_err_o, 0);
        rst_n = 1'b1;
        wait_pulse(t);
        chk("R4 default after reset", t, 48);
        wait_pulse(t2);
        chk("R4 second period", t2 - t, 48);
        chk("R8 err stays low", cfg_err_o, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R1: got 0 expected 1 (run did not complete)");
            summary();
            $finish;
        end
    end
endmodule